// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel LCD panel. It divides the logic clock down to the pixel rate and emits a single-cycle pixel strobe. It steps a horizontal and a vertical position counter with that strobe and decodes from them the horizontal and vertical sync pulses, the active-video window and the pixel coordinates inside it. It also emits a strobe at the end of every line and at the end of every frame, which the pixel data path can use to realign.

All timing comes from three 32-bit configuration words that are supplied as static inputs. The horizontal word holds every length minus one, so no field can encode a zero-length segment. The vertical word holds the line count and the sync width minus one, but stores both vertical porches at their true value, so those porches may be zero. The clock word holds the 8-bit divider and a polarity field. A panel-type input picks TFT or passive operation, and this choice sets the smallest divider the block will use. The configuration is expected to change only while reset is held.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `rst` is high, `pix_ce`, `eol`, `eof`, `pix_x` and `pix_y` are 0, `hsync` and `vsync` show their asserted level, `de` shows its inactive level and `pclk_out` shows its low level. Each level is taken after the polarity inversion of R7.
- R2: `pix_ce` is high for exactly one logic cycle in every D cycles. D is `cfg_clock[7:0]`, raised to 2 when `panel_tft`=1 or to 3 when `panel_tft`=0 if the field is below that floor. The first strobe comes D cycles after reset is released.
- R3: A line runs through four horizontal segments in this order: sync (`cfg_horiz[15:10]`+1 pixels), back porch (`cfg_horiz[31:24]`+1), active (`cfg_horiz[9:0]`+1) and front porch (`cfg_horiz[23:16]`+1). `hsync` is asserted only during the sync segment.
- R4: A frame runs through four vertical segments in this order: sync (`cfg_vert[15:10]`+1 lines), back porch (`cfg_vert[31:24]` lines, may be 0), active (`cfg_vert[9:0]`+1) and front porch (`cfg_vert[23:16]` lines, may be 0). `vsync` is asserted only during the vertical sync lines.
- R5: `de` is asserted only when both axes are in their active segment. Within that segment, `pix_x` and `pix_y` count up from 0. Outside their own active segment they read 0.
- R6: `eol` is high together with the `pix_ce` of the last pixel of each line. `eof` is high together with the `eol` of the last line of the frame, which is the last cycle of the vertical front porch. Neither pulses at any other time.
- R7: When a bit of `cfg_clock` is 1, it inverts one output: bit 20 inverts `hsync`, bit 21 inverts `vsync`, bit 22 inverts `pclk_out` and bit 23 inverts `de`. Bits 24 and 25 have no effect on any output.
- R8: Before inversion, `pclk_out` is low for the first floor(D/2) logic cycles of each pixel period and high for the rest of that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_horiz | input | 32 | Horizontal timing word |
| cfg_vert | input | 32 | Vertical timing word |
| cfg_clock | input | 32 | Divider and polarity word |
| panel_tft | input | 1 | 1 selects a TFT panel, 0 selects a passive panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-video enable |
| pclk_out | output | 1 | Pixel clock waveform for the panel |
| pix_ce | output | 1 | One-cycle pixel strobe |
| pix_x | output | 10 | Column within the active area |
| pix_y | output | 10 | Row within the active area |
| eol | output | 1 | End-of-line strobe |
| eof | output | 1 | End-of-frame strobe |

## Verification
The assertions check four rules on every cycle. Two pixel strobes are never adjacent. Each axis moves forward through its segments and returns to sync after it wraps. `eof` never appears without `eol`. Data-enable never overlaps horizontal sync.

The exact segment lengths are shown only by the bench scenarios. The same holds for the zero-length vertical porches, the coordinates, the divider floor and the maximum divider value, and the effect of each polarity bit, including the two ignored ones. For these, the bench compares every pixel strobe of whole frames against a model built from the requirements.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam int TG_CNT_W = 12;
    localparam int TG_DIV_W = 8;

    typedef logic [TG_CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    typedef struct packed {
        cnt_t sync_len;
        cnt_t back_len;
        cnt_t act_len;
        cnt_t front_len;
    } seg_t;

    typedef struct packed {
        logic inv_de;
        logic inv_clk;
        logic inv_v;
        logic inv_h;
    } pol_t;

    // horizontal word: every field is stored minus one
    function automatic seg_t unpack_horiz(input logic [31:0] w);
        seg_t s;
        s.act_len   = TG_CNT_W'(w[9:0])   + TG_CNT_W'(1);
        s.sync_len  = TG_CNT_W'(w[15:10]) + TG_CNT_W'(1);
        s.front_len = TG_CNT_W'(w[23:16]) + TG_CNT_W'(1);
        s.back_len  = TG_CNT_W'(w[31:24]) + TG_CNT_W'(1);
        return s;
    endfunction

    // vertical word: porches are stored at their true value
    function automatic seg_t unpack_vert(input logic [31:0] w);
        seg_t s;
        s.act_len   = TG_CNT_W'(w[9:0])   + TG_CNT_W'(1);
        s.sync_len  = TG_CNT_W'(w[15:10]) + TG_CNT_W'(1);
        s.front_len = TG_CNT_W'(w[23:16]);
        s.back_len  = TG_CNT_W'(w[31:24]);
        return s;
    endfunction

    function automatic logic [TG_DIV_W-1:0] eff_divider(input logic [31:0] w,
                                                        input logic tft);
        logic [TG_DIV_W-1:0] floor_v;
        floor_v = tft ? TG_DIV_W'(2) : TG_DIV_W'(3);
        return (w[TG_DIV_W-1:0] < floor_v) ? floor_v : w[TG_DIV_W-1:0];
    endfunction

    function automatic pol_t unpack_pol(input logic [31:0] w);
        pol_t p;
        p.inv_h   = w[20];
        p.inv_v   = w[21];
        p.inv_clk = w[22];
        p.inv_de  = w[23];
        return p;
    endfunction

endpackage

// File: rtl/tgen_clkdiv.sv
module tgen_clkdiv
    import tgen_pkg::*;
#(
    parameter int DW = TG_DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div,
    output logic          ce,
    output logic          phase_hi
);

    logic [DW-1:0] cnt;
    logic [DW-1:0] last;

    assign last     = div - DW'(1);
    assign ce       = (cnt >= last);
    assign phase_hi = (cnt >= (div >> 1));

    always_ff @(posedge clk) begin
        if (rst)     cnt <= '0;
        else if (ce) cnt <= '0;
        else         cnt <= cnt + DW'(1);
    end

    // divider floor is 2, so strobes can never be back to back
    p_ce_gap_r2: assert property (@(posedge clk) disable iff (rst)
        ce |=> !ce);

endmodule

// File: rtl/tgen_axis.sv
module tgen_axis
    import tgen_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  seg_t             seg,
    output phase_e           phase,
    output logic [POS_W-1:0] pos,
    output logic             wrap
);

    cnt_t cnt;
    cnt_t b_back, b_act, b_front, total;

    assign b_back  = seg.sync_len;
    assign b_act   = b_back + seg.back_len;
    assign b_front = b_act + seg.act_len;
    assign total   = b_front + seg.front_len;
    assign wrap    = (cnt >= total - TG_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= wrap ? '0 : cnt + TG_CNT_W'(1);
    end

    always_comb begin
        if (cnt < b_back)       phase = PH_SYNC;
        else if (cnt < b_act)   phase = PH_BACK;
        else if (cnt < b_front) phase = PH_ACT;
        else                    phase = PH_FRONT;
    end

    assign pos = (phase == PH_ACT) ? POS_W'(cnt - b_act) : '0;

    // segments advance in order within one pass
    p_phase_order_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !wrap) |=> (phase >= $past(phase)));

    // every pass restarts in the sync segment
    p_wrap_sync_r4: assert property (@(posedge clk) disable iff (rst)
        (step && wrap) |=> (phase == PH_SYNC));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import tgen_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      cfg_horiz,
    input  logic [31:0]      cfg_vert,
    input  logic [31:0]      cfg_clock,
    input  logic             panel_tft,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             pclk_out,
    output logic             pix_ce,
    output logic [POS_W-1:0] pix_x,
    output logic [POS_W-1:0] pix_y,
    output logic             eol,
    output logic             eof
);

    seg_t                h_seg, v_seg;
    pol_t                pol;
    logic [TG_DIV_W-1:0] div_eff;
    phase_e              h_phase, v_phase;
    logic                h_wrap, v_wrap, clk_hi;
    logic                h_sync_raw, de_raw;
    logic                unused_cfg_bits;

    assign h_seg   = unpack_horiz(cfg_horiz);
    assign v_seg   = unpack_vert(cfg_vert);
    assign pol     = unpack_pol(cfg_clock);
    assign div_eff = eff_divider(cfg_clock, panel_tft);
    assign unused_cfg_bits = ^{cfg_clock[31:24], cfg_clock[19:8]};

    tgen_clkdiv #(.DW(TG_DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .div      (div_eff),
        .ce       (pix_ce),
        .phase_hi (clk_hi)
    );

    tgen_axis #(.POS_W(POS_W)) u_horiz (
        .clk   (clk),
        .rst   (rst),
        .step  (pix_ce),
        .seg   (h_seg),
        .phase (h_phase),
        .pos   (pix_x),
        .wrap  (h_wrap)
    );

    tgen_axis #(.POS_W(POS_W)) u_vert (
        .clk   (clk),
        .rst   (rst),
        .step  (eol),
        .seg   (v_seg),
        .phase (v_phase),
        .pos   (pix_y),
        .wrap  (v_wrap)
    );

    assign eol        = pix_ce & h_wrap;
    assign eof        = eol & v_wrap;
    assign h_sync_raw = (h_phase == PH_SYNC);
    assign de_raw     = (h_phase == PH_ACT) && (v_phase == PH_ACT);

    assign hsync    = h_sync_raw ^ pol.inv_h;
    assign vsync    = (v_phase == PH_SYNC) ^ pol.inv_v;
    assign de       = de_raw ^ pol.inv_de;
    assign pclk_out = clk_hi ^ pol.inv_clk;

    p_eof_in_eol_r6: assert property (@(posedge clk) disable iff (rst)
        eof |-> eol);

    p_de_outside_hsync_r5: assert property (@(posedge clk) disable iff (rst)
        ((de ^ pol.inv_de) |-> !(hsync ^ pol.inv_h)));

endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_horiz = '0, cfg_vert = '0, cfg_clock = '0;
    logic        panel_tft = 1'b1;
    logic        hsync, vsync, de, pclk_out, pix_ce, eol, eof;
    logic [9:0]  pix_x, pix_y;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_timing_gen uut (
        .clk(clk), .rst(rst), .cfg_horiz(cfg_horiz), .cfg_vert(cfg_vert),
        .cfg_clock(cfg_clock), .panel_tft(panel_tft), .hsync(hsync),
        .vsync(vsync), .de(de), .pclk_out(pclk_out), .pix_ce(pix_ce),
        .pix_x(pix_x), .pix_y(pix_y), .eol(eol), .eof(eof)
    );

    typedef struct {
        bit hs, vs, de, eol, eof;
        int x, y;
    } exp_t;

    exp_t     exp_q[$];
    int       n_tests = 0, n_fail = 0;
    bit       armed = 0;
    int       cur_div = 2;
    bit [3:0] cur_pol = '0;
    int       k = 0;
    int       cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: pops one expected item per pixel strobe
    always @(negedge clk) begin
        if (rst || !armed) begin
            k = 0;
        end else begin
            chk(pclk_out == ((k >= cur_div/2) ^ cur_pol[2]), "R8", "pclk_out",
                pclk_out, (k >= cur_div/2) ^ cur_pol[2]);
            if (pix_ce) begin
                chk(k == cur_div-1, "R2", "pixel period", k+1, cur_div);
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected pixel strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(hsync == (e.hs ^ cur_pol[0]), "R3", "hsync", hsync, e.hs ^ cur_pol[0]);
                    chk(vsync == (e.vs ^ cur_pol[1]), "R4", "vsync", vsync, e.vs ^ cur_pol[1]);
                    chk(de == (e.de ^ cur_pol[3]), "R5", "de", de, e.de ^ cur_pol[3]);
                    chk(pix_x == e.x, "R5", "pix_x", pix_x, e.x);
                    chk(pix_y == e.y, "R5", "pix_y", pix_y, e.y);
                    chk(eol == e.eol, "R6", "eol", eol, e.eol);
                    chk(eof == e.eof, "R6", "eof", eof, e.eof);
                    if (exp_q.size() == 0) armed = 0;
                end
                k = 0;
            end else begin
                chk(!eol && !eof, "R6", "line/frame strobe off pixel strobe",
                    eol | eof, 0);
                k++;
            end
        end
    end

    task automatic run_case(input string name,
                            input int ppl, input int hsw, input int hfp, input int hbp,
                            input int lines, input int vsw, input int vfp, input int vbp,
                            input int divf, input bit tft, input bit [5:0] pol6,
                            input int frames);
        int htot, vtot, hb, ha, vb, va;
        $display("[TB] case: %s", name);
        @(posedge clk);
        rst       <= 1'b1;
        cfg_horiz <= {8'(hbp-1), 8'(hfp-1), 6'(hsw-1), 10'(ppl-1)};
        cfg_vert  <= {8'(vbp), 8'(vfp), 6'(vsw-1), 10'(lines-1)};
        cfg_clock <= {6'b0, pol6, 4'b0, 8'hA5, 8'(divf)};
        panel_tft <= tft;
        cur_div = (divf < (tft ? 2 : 3)) ? (tft ? 2 : 3) : divf;
        cur_pol = pol6[3:0];
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(pix_ce == 0 && eol == 0 && eof == 0, "R1", "strobes in reset",
            {pix_ce, eol, eof}, 0);
        chk(pix_x == 0 && pix_y == 0, "R1", "coordinates in reset", pix_x + pix_y, 0);
        chk(hsync == !cur_pol[0], "R1", "hsync in reset", hsync, !cur_pol[0]);
        chk(vsync == !cur_pol[1], "R1", "vsync in reset", vsync, !cur_pol[1]);
        chk(de == cur_pol[3], "R1", "de in reset", de, cur_pol[3]);
        chk(pclk_out == cur_pol[2], "R1", "pclk_out in reset", pclk_out, cur_pol[2]);
        // expected raster built from R3..R6
        htot = hsw + hbp + ppl + hfp;
        vtot = vsw + vbp + lines + vfp;
        hb = hsw; ha = hsw + hbp;
        vb = vsw; va = vsw + vbp;
        for (int f = 0; f < frames; f++)
            for (int v = 0; v < vtot; v++)
                for (int h = 0; h < htot; h++) begin
                    exp_t e;
                    bit hact, vact;
                    hact  = (h >= ha) && (h < ha + ppl);
                    vact  = (v >= va) && (v < va + lines);
                    e.hs  = (h < hb);
                    e.vs  = (v < vb);
                    e.de  = hact && vact;
                    e.x   = hact ? h - ha : 0;
                    e.y   = vact ? v - va : 0;
                    e.eol = (h == htot-1);
                    e.eof = (h == htot-1) && (v == vtot-1);
                    exp_q.push_back(e);
                end
        armed = 1;
        @(posedge clk);
        rst <= 1'b0;
        wait (!armed);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R2 TFT floor: field 0 becomes 2
        run_case("tft divider floor", 4, 2, 1, 2, 3, 1, 1, 1, 0, 1'b1, 6'b000000, 2);
        // R2 passive floor, R4 zero porches, R7 all inversions with bits 24/25 set
        run_case("passive floor, zero porches, all polarity bits",
                 3, 1, 2, 1, 2, 2, 0, 0, 2, 1'b0, 6'b111111, 2);
        // R3/R8 odd divider, R7 hsync and pclk inversion only
        run_case("tft divider 5", 5, 1, 1, 3, 2, 1, 2, 2, 5, 1'b1, 6'b000101, 1);
        // R2 passive floor from a field of 1
        run_case("passive divider 1", 2, 1, 1, 1, 2, 1, 1, 0, 1, 1'b0, 6'b000000, 1);
        // R2 maximum divider, R7 vsync and de inversion
        run_case("divider 255", 1, 1, 1, 1, 1, 1, 0, 0, 255, 1'b0, 6'b001010, 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule